// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block is the entry half of a processor's exception machinery. When the pipeline raises an exception it presents a kind code, the faulting PC, delay-slot and ISA-mode flags, and the current contents of the status, cause, saved-PC and debug registers. One clock later the block returns the complete register image after entry and the address of the first handler instruction.

Exceptions fall into three classes. Normal exceptions save the resume PC only when the exception level is clear, set that level, and vector relative to either the boot base or a programmable base. Interrupts may also use vectored offsets with a programmable spacing. Reset-class events save to an error register and jump to a fixed reset address. Debug-class events save to a debug register, raise debug mode and jump to a fixed debug address. Every accepted entry drops the privilege field to kernel.

The block holds no architectural state. The register image goes in with the request and comes out with the result, so the register file stays with its owner. Outputs hold between entries.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released without a request, `ent_valid`, `ent_pc` and every register output are zero.
- R2: Kind codes are 0 reset, 1 soft reset, 2 NMI, 3 single step, 4 debug interrupt, 5 instruction break, 6 break-instruction debug, 7 data-break store, 8 data-break load, 9 interrupt, 10 modify, 11 TLB load, 12 TLB store, 13 address-error load, 14 address-error store, 15 syscall, 16 break, 17 reserved instruction, 18 coprocessor unusable, 19 overflow, 20 trap. For a request with kind 0..20, `ent_valid` is high in the cycle after `exc_valid` and low otherwise. Kinds 21..31 produce no entry and leave every output unchanged.
- R3: The resume PC is `cur_pc | isa16`, minus 4 when `in_dslot` is set, or minus 2 when `in_dslot` and `dslot_b16` are both set.
- R4: For a normal exception with `st_exl` clear, `out_epc` takes the resume PC and `out_bd` takes `in_dslot`. With `st_exl` set, both pass through unchanged. `out_exl` is 1 afterwards.
- R5: The normal handler address is a base plus an offset. The base is 0xBFC00200 when `st_bev` is set, and `ebase` with bits 9:0 cleared otherwise. The offset is 0x000 for TLB load or store with `exc_refill` set and `st_exl` clear, and 0x180 for every other non-interrupt exception.
- R6: The interrupt offset is 0x180 when `ca_iv` is clear, and 0x200 when `ca_iv` is set with both vector modes off. When `ca_iv` and a vector mode are on, the offset is 0x200 + vector × (`vi_space` << 5). With `vi_internal` set, the vector is the index of the highest set bit of `ca_ip`, or 0 if none is set. With only `vi_external` set, the vector is `ca_ip` itself.
- R7: A normal exception writes `out_code` as 0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4/5 address error load/store, 8 syscall, 9 break, 10 reserved, 11 coprocessor unusable, 12 overflow, 13 trap. `out_ce` takes `exc_cop` only for coprocessor unusable and otherwise passes `ca_ce`.
- R8: Reset-class kinds save the resume PC in `out_errepc`, set `out_erl` and `out_bev`, and target 0xBFC00000. Soft reset also sets `out_sr`, and NMI sets `out_nmi`. `out_bd` is cleared when `st_exl` is clear.
- R9: Debug-class kinds OR one flag into `out_dbg_flags` (bit0 single step, bit1 break instruction, bit2 data-break load, bit3 data-break store, bit4 instruction break, bit5 debug interrupt), set `out_dbg_mode`, and target 0xBFC00480. They save `out_depc` as the resume PC, except single step, which saves `cur_pc | isa16`. `out_exl` and `out_erl` pass through, and `out_bd` is cleared when `st_exl` is clear.
- R10: An interrupt request while `dbg_mode_in` is set is taken as a debug interrupt (R9, bit5), and the cause code passes through.
- R11: Every accepted entry sets `out_ksu` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request this cycle |
| exc_kind | input | 5 | Exception kind code (R2) |
| exc_refill | input | 1 | TLB miss found no entry (refill) |
| exc_cop | input | 2 | Coprocessor number for coprocessor unusable |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_dslot | input | 1 | Exception taken in a branch delay slot |
| dslot_b16 | input | 1 | The branch owning the slot is a 16-bit one |
| isa16 | input | 1 | 16-bit ISA mode is active |
| st_exl | input | 1 | Current exception level |
| st_erl | input | 1 | Current error level |
| st_bev | input | 1 | Current boot-vector select |
| st_sr | input | 1 | Current soft-reset flag |
| st_nmi | input | 1 | Current NMI flag |
| st_ksu | input | 2 | Current privilege field |
| ca_iv | input | 1 | Interrupts use the special offset |
| ca_bd | input | 1 | Current delay-slot record |
| ca_code | input | 5 | Current exception code |
| ca_ce | input | 2 | Current coprocessor number field |
| ca_ip | input | IP_W | Pending interrupt lines |
| ebase | input | 32 | Programmable exception base |
| vi_internal | input | 1 | Internally vectored interrupts on |
| vi_external | input | 1 | Externally supplied vectors on |
| vi_space | input | SPACE_W | Vector spacing field |
| epc_in | input | 32 | Current exception PC |
| errepc_in | input | 32 | Current error PC |
| depc_in | input | 32 | Current debug PC |
| dbg_mode_in | input | 1 | Currently in debug mode |
| dbg_flags_in | input | 6 | Current debug cause flags |
| ent_valid | output | 1 | Entry result valid |
| ent_pc | output | 32 | Handler start address |
| out_exl | output | 1 | Exception level after entry |
| out_erl | output | 1 | Error level after entry |
| out_bev | output | 1 | Boot-vector select after entry |
| out_sr | output | 1 | Soft-reset flag after entry |
| out_nmi | output | 1 | NMI flag after entry |
| out_ksu | output | 2 | Privilege field after entry |
| out_bd | output | 1 | Delay-slot record after entry |
| out_code | output | 5 | Exception code after entry |
| out_ce | output | 2 | Coprocessor number after entry |
| out_epc | output | 32 | Exception PC after entry |
| out_errepc | output | 32 | Error PC after entry |
| out_depc | output | 32 | Debug PC after entry |
| out_dbg_mode | output | 1 | Debug mode after entry |
| out_dbg_flags | output | 6 | Debug cause flags after entry |

## Verification
Every result, including the handler address and each saved register, passes through exactly one register. It is therefore due at the first rising edge after the request is sampled. The bench drives each request on a falling edge and samples all outputs on the next falling edge, half a period after that rising edge. It then drops the request before the following edge. A request with an unused kind is checked at the same point: it must show no valid pulse and unchanged outputs.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int ADDR_W = 32;
  localparam int KIND_W = 5;
  localparam int CODE_W = 5;
  localparam int DBG_W  = 6;

  typedef enum logic [KIND_W-1:0] {
    EK_RESET  = 5'd0,  EK_SRESET = 5'd1,  EK_NMI   = 5'd2,
    EK_DSS    = 5'd3,  EK_DINT   = 5'd4,  EK_DIB   = 5'd5,
    EK_DBP    = 5'd6,  EK_DDBS   = 5'd7,  EK_DDBL  = 5'd8,
    EK_INT    = 5'd9,  EK_MOD    = 5'd10, EK_TLBL  = 5'd11,
    EK_TLBS   = 5'd12, EK_ADEL   = 5'd13, EK_ADES  = 5'd14,
    EK_SYS    = 5'd15, EK_BRK    = 5'd16, EK_RI    = 5'd17,
    EK_CPU    = 5'd18, EK_OV     = 5'd19, EK_TRAP  = 5'd20
  } exc_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_RESET  = 2'd2,
    CLS_DEBUG  = 2'd3
  } exc_class_e;

  // cause codes written for normal exceptions
  localparam logic [CODE_W-1:0] CC_INT  = 5'd0;
  localparam logic [CODE_W-1:0] CC_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] CC_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] CC_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] CC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] CC_ADES = 5'd5;
  localparam logic [CODE_W-1:0] CC_SYS  = 5'd8;
  localparam logic [CODE_W-1:0] CC_BRK  = 5'd9;
  localparam logic [CODE_W-1:0] CC_RI   = 5'd10;
  localparam logic [CODE_W-1:0] CC_CPU  = 5'd11;
  localparam logic [CODE_W-1:0] CC_OV   = 5'd12;
  localparam logic [CODE_W-1:0] CC_TRAP = 5'd13;

  // debug flag bit positions
  localparam int DB_SS  = 0;
  localparam int DB_BP  = 1;
  localparam int DB_DBL = 2;
  localparam int DB_DBS = 3;
  localparam int DB_IB  = 4;
  localparam int DB_INT = 5;

  localparam logic [ADDR_W-1:0] RESET_VEC   = 32'hBFC0_0000;
  localparam logic [ADDR_W-1:0] DEBUG_VEC   = 32'hBFC0_0480;
  localparam logic [ADDR_W-1:0] BOOT_BASE   = 32'hBFC0_0200;
  localparam logic [ADDR_W-1:0] EBASE_KEEP  = ~32'h0000_03FF;
  localparam logic [ADDR_W-1:0] OFF_REFILL  = 32'h0000_0000;
  localparam logic [ADDR_W-1:0] OFF_GENERAL = 32'h0000_0180;
  localparam logic [ADDR_W-1:0] OFF_INTVEC  = 32'h0000_0200;
  localparam logic [ADDR_W-1:0] STEP_WORD   = 32'd4;
  localparam logic [ADDR_W-1:0] STEP_HALF   = 32'd2;

  typedef struct packed {
    logic              exl;
    logic              erl;
    logic              bev;
    logic              sr;
    logic              nmi;
    logic [1:0]        ksu;
    logic              bd;
    logic [CODE_W-1:0] code;
    logic [1:0]        ce;
    logic [ADDR_W-1:0] epc;
    logic [ADDR_W-1:0] errepc;
    logic [ADDR_W-1:0] depc;
    logic              dbg_mode;
    logic [DBG_W-1:0]  dbg_flags;
  } exc_image_t;

  // PC at which execution resumes after the handler
  function automatic logic [ADDR_W-1:0] f_resume_pc(
    input logic [ADDR_W-1:0] pc,
    input logic              isa16,
    input logic              dslot,
    input logic              b16
  );
    logic [ADDR_W-1:0] r;
    r = pc | {{(ADDR_W-1){1'b0}}, isa16};
    if (dslot) r = r - (b16 ? STEP_HALF : STEP_WORD);
    return r;
  endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              dbg_mode,
  output exc_class_e        cls,
  output logic [CODE_W-1:0] code,
  output logic [DBG_W-1:0]  dbg_hit,
  output logic              is_int,
  output logic              is_tlb,
  output logic              is_cpu,
  output logic              is_sreset,
  output logic              is_nmi,
  output logic              is_sstep
);

  always_comb begin
    cls       = CLS_NONE;
    code      = CC_INT;
    dbg_hit   = '0;
    is_int    = 1'b0;
    is_tlb    = 1'b0;
    is_cpu    = 1'b0;
    is_sreset = 1'b0;
    is_nmi    = 1'b0;
    is_sstep  = 1'b0;
    case (kind)
      EK_RESET:  cls = CLS_RESET;
      EK_SRESET: begin cls = CLS_RESET; is_sreset = 1'b1; end
      EK_NMI:    begin cls = CLS_RESET; is_nmi = 1'b1; end
      EK_DSS:    begin cls = CLS_DEBUG; dbg_hit[DB_SS] = 1'b1; is_sstep = 1'b1; end
      EK_DINT:   begin cls = CLS_DEBUG; dbg_hit[DB_INT] = 1'b1; end
      EK_DIB:    begin cls = CLS_DEBUG; dbg_hit[DB_IB] = 1'b1; end
      EK_DBP:    begin cls = CLS_DEBUG; dbg_hit[DB_BP] = 1'b1; end
      EK_DDBS:   begin cls = CLS_DEBUG; dbg_hit[DB_DBS] = 1'b1; end
      EK_DDBL:   begin cls = CLS_DEBUG; dbg_hit[DB_DBL] = 1'b1; end
      EK_INT: begin
        if (dbg_mode) begin
          // interrupt arriving in debug mode becomes a debug interrupt
          cls = CLS_DEBUG;
          dbg_hit[DB_INT] = 1'b1;
        end else begin
          cls    = CLS_NORMAL;
          is_int = 1'b1;
          code   = CC_INT;
        end
      end
      EK_MOD:  begin cls = CLS_NORMAL; code = CC_MOD; end
      EK_TLBL: begin cls = CLS_NORMAL; code = CC_TLBL; is_tlb = 1'b1; end
      EK_TLBS: begin cls = CLS_NORMAL; code = CC_TLBS; is_tlb = 1'b1; end
      EK_ADEL: begin cls = CLS_NORMAL; code = CC_ADEL; end
      EK_ADES: begin cls = CLS_NORMAL; code = CC_ADES; end
      EK_SYS:  begin cls = CLS_NORMAL; code = CC_SYS; end
      EK_BRK:  begin cls = CLS_NORMAL; code = CC_BRK; end
      EK_RI:   begin cls = CLS_NORMAL; code = CC_RI; end
      EK_CPU:  begin cls = CLS_NORMAL; code = CC_CPU; is_cpu = 1'b1; end
      EK_OV:   begin cls = CLS_NORMAL; code = CC_OV; end
      EK_TRAP: begin cls = CLS_NORMAL; code = CC_TRAP; end
      default: cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int IP_W        = 8,
  parameter int SPACE_W     = 5,
  parameter int SPACE_SHIFT = 5
) (
  input  exc_class_e         cls,
  input  logic               is_int,
  input  logic               is_tlb,
  input  logic               refill,
  input  logic               exl,
  input  logic               bev,
  input  logic [ADDR_W-1:0]  ebase,
  input  logic               iv,
  input  logic               vint,
  input  logic               veic,
  input  logic [SPACE_W-1:0] space,
  input  logic [IP_W-1:0]    ip,
  output logic [ADDR_W-1:0]  offset,
  output logic [ADDR_W-1:0]  target
);

  localparam int VEC_W = (IP_W > 1) ? $clog2(IP_W) : 1;

  // index of the highest pending line, zero when none pends
  function automatic logic [VEC_W-1:0] f_highest(input logic [IP_W-1:0] lines);
    logic [VEC_W-1:0] h;
    h = '0;
    for (int i = 0; i < IP_W; i++) begin
      if (lines[i]) h = VEC_W'(i);
    end
    return h;
  endfunction

  // vectored interrupt offset for a given vector number
  function automatic logic [ADDR_W-1:0] f_spaced(
    input logic [ADDR_W-1:0]  vec,
    input logic [SPACE_W-1:0] sp
  );
    logic [ADDR_W-1:0] step;
    step = ADDR_W'(sp) << SPACE_SHIFT;
    return OFF_INTVEC + vec * step;
  endfunction

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] vec_num;

  always_comb begin
    if (vint) vec_num = ADDR_W'(f_highest(ip));
    else      vec_num = ADDR_W'(ip);
  end

  always_comb begin
    base = bev ? BOOT_BASE : (ebase & EBASE_KEEP);
    if (is_int) begin
      if (!iv)              offset = OFF_GENERAL;
      else if (vint || veic) offset = f_spaced(vec_num, space);
      else                  offset = OFF_INTVEC;
    end else if (is_tlb && refill && !exl) begin
      offset = OFF_REFILL;
    end else begin
      offset = OFF_GENERAL;
    end
    case (cls)
      CLS_RESET: target = RESET_VEC;
      CLS_DEBUG: target = DEBUG_VEC;
      default:   target = base + offset;
    endcase
  end

endmodule

// File: rtl/exc_state_next.sv
module exc_state_next
  import exc_entry_pkg::*;
(
  input  exc_class_e        cls,
  input  logic [CODE_W-1:0] code,
  input  logic [DBG_W-1:0]  dbg_hit,
  input  logic              is_cpu,
  input  logic              is_sreset,
  input  logic              is_nmi,
  input  logic              is_sstep,
  input  logic [1:0]        cop,
  input  logic [ADDR_W-1:0] pc,
  input  logic              isa16,
  input  logic              dslot,
  input  logic              b16,
  input  exc_image_t        cur,
  output logic [ADDR_W-1:0] resume,
  output exc_image_t        nxt
);

  always_comb begin
    resume = f_resume_pc(pc, isa16, dslot, b16);
    nxt    = cur;
    nxt.ksu = 2'b00;
    case (cls)
      CLS_NORMAL: begin
        if (!cur.exl) begin
          nxt.epc = resume;
          nxt.bd  = dslot;
        end
        nxt.exl  = 1'b1;
        nxt.code = code;
        if (is_cpu) nxt.ce = cop;
      end
      CLS_RESET: begin
        nxt.errepc = resume;
        nxt.erl    = 1'b1;
        nxt.bev    = 1'b1;
        if (is_sreset) nxt.sr  = 1'b1;
        if (is_nmi)    nxt.nmi = 1'b1;
        if (!cur.exl)  nxt.bd  = 1'b0;
      end
      CLS_DEBUG: begin
        nxt.dbg_flags = cur.dbg_flags | dbg_hit;
        nxt.depc      = is_sstep ? (pc | {{(ADDR_W-1){1'b0}}, isa16}) : resume;
        nxt.dbg_mode  = 1'b1;
        if (!cur.exl) nxt.bd = 1'b0;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int IP_W        = 8,
  parameter int SPACE_W     = 5,
  parameter int SPACE_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [4:0]         exc_kind,
  input  logic               exc_refill,
  input  logic [1:0]         exc_cop,
  input  logic [31:0]        cur_pc,
  input  logic               in_dslot,
  input  logic               dslot_b16,
  input  logic               isa16,
  input  logic               st_exl,
  input  logic               st_erl,
  input  logic               st_bev,
  input  logic               st_sr,
  input  logic               st_nmi,
  input  logic [1:0]         st_ksu,
  input  logic               ca_iv,
  input  logic               ca_bd,
  input  logic [4:0]         ca_code,
  input  logic [1:0]         ca_ce,
  input  logic [IP_W-1:0]    ca_ip,
  input  logic [31:0]        ebase,
  input  logic               vi_internal,
  input  logic               vi_external,
  input  logic [SPACE_W-1:0] vi_space,
  input  logic [31:0]        epc_in,
  input  logic [31:0]        errepc_in,
  input  logic [31:0]        depc_in,
  input  logic               dbg_mode_in,
  input  logic [5:0]         dbg_flags_in,
  output logic               ent_valid,
  output logic [31:0]        ent_pc,
  output logic               out_exl,
  output logic               out_erl,
  output logic               out_bev,
  output logic               out_sr,
  output logic               out_nmi,
  output logic [1:0]         out_ksu,
  output logic               out_bd,
  output logic [4:0]         out_code,
  output logic [1:0]         out_ce,
  output logic [31:0]        out_epc,
  output logic [31:0]        out_errepc,
  output logic [31:0]        out_depc,
  output logic               out_dbg_mode,
  output logic [5:0]         out_dbg_flags
);

  // named internal events, also observed by the bound checker
  exc_class_e        cls_now;
  exc_class_e        cls_q;
  logic [CODE_W-1:0] code_now;
  logic [DBG_W-1:0]  dbg_hit;
  logic              is_int, is_tlb, is_cpu, is_sreset, is_nmi, is_sstep;
  logic [ADDR_W-1:0] vec_offset;
  logic [ADDR_W-1:0] vec_target;
  logic [ADDR_W-1:0] resume_pc;
  logic              take_now;
  exc_image_t        cur_img;
  exc_image_t        nxt_img;
  exc_image_t        img_q;
  logic              valid_q;
  logic [ADDR_W-1:0] pc_q;

  always_comb begin
    cur_img.exl       = st_exl;
    cur_img.erl       = st_erl;
    cur_img.bev       = st_bev;
    cur_img.sr        = st_sr;
    cur_img.nmi       = st_nmi;
    cur_img.ksu       = st_ksu;
    cur_img.bd        = ca_bd;
    cur_img.code      = ca_code;
    cur_img.ce        = ca_ce;
    cur_img.epc       = epc_in;
    cur_img.errepc    = errepc_in;
    cur_img.depc      = depc_in;
    cur_img.dbg_mode  = dbg_mode_in;
    cur_img.dbg_flags = dbg_flags_in;
  end

  exc_classify u_cls (
    .kind      (exc_kind),
    .dbg_mode  (dbg_mode_in),
    .cls       (cls_now),
    .code      (code_now),
    .dbg_hit   (dbg_hit),
    .is_int    (is_int),
    .is_tlb    (is_tlb),
    .is_cpu    (is_cpu),
    .is_sreset (is_sreset),
    .is_nmi    (is_nmi),
    .is_sstep  (is_sstep)
  );

  exc_vector_gen #(
    .IP_W        (IP_W),
    .SPACE_W     (SPACE_W),
    .SPACE_SHIFT (SPACE_SHIFT)
  ) u_vec (
    .cls    (cls_now),
    .is_int (is_int),
    .is_tlb (is_tlb),
    .refill (exc_refill),
    .exl    (st_exl),
    .bev    (st_bev),
    .ebase  (ebase),
    .iv     (ca_iv),
    .vint   (vi_internal),
    .veic   (vi_external),
    .space  (vi_space),
    .ip     (ca_ip),
    .offset (vec_offset),
    .target (vec_target)
  );

  exc_state_next u_nxt (
    .cls       (cls_now),
    .code      (code_now),
    .dbg_hit   (dbg_hit),
    .is_cpu    (is_cpu),
    .is_sreset (is_sreset),
    .is_nmi    (is_nmi),
    .is_sstep  (is_sstep),
    .cop       (exc_cop),
    .pc        (cur_pc),
    .isa16     (isa16),
    .dslot     (in_dslot),
    .b16       (dslot_b16),
    .cur       (cur_img),
    .resume    (resume_pc),
    .nxt       (nxt_img)
  );

  assign take_now = exc_valid && (cls_now != CLS_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      img_q   <= '0;
      cls_q   <= CLS_NONE;
    end else begin
      valid_q <= take_now;
      if (take_now) begin
        pc_q  <= vec_target;
        img_q <= nxt_img;
        cls_q <= cls_now;
      end
    end
  end

  assign ent_valid     = valid_q;
  assign ent_pc        = pc_q;
  assign out_exl       = img_q.exl;
  assign out_erl       = img_q.erl;
  assign out_bev       = img_q.bev;
  assign out_sr        = img_q.sr;
  assign out_nmi       = img_q.nmi;
  assign out_ksu       = img_q.ksu;
  assign out_bd        = img_q.bd;
  assign out_code      = img_q.code;
  assign out_ce        = img_q.ce;
  assign out_epc       = img_q.epc;
  assign out_errepc    = img_q.errepc;
  assign out_depc      = img_q.depc;
  assign out_dbg_mode  = img_q.dbg_mode;
  assign out_dbg_flags = img_q.dbg_flags;

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_entry_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic        st_exl,
  input logic [31:0] epc_in,
  input logic [5:0]  dbg_flags_in,
  input logic        ent_valid,
  input logic [31:0] ent_pc,
  input logic        out_erl,
  input logic        out_dbg_mode,
  input logic [1:0]  out_ksu,
  input logic [31:0] out_epc,
  input logic [5:0]  out_dbg_flags,
  input exc_class_e  cls_now,
  input exc_class_e  cls_q
);

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> $past(exc_valid)) else $error("valid without request"); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> (!ent_valid && $stable(ent_pc) && $stable(out_epc))) else $error("idle changed outputs"); // R2

  AST_EPC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && st_exl && cls_now == CLS_NORMAL) |=> (out_epc == $past(epc_in))) else $error("epc overwritten"); // R4

  AST_KERNEL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (out_ksu == 2'b00)) else $error("privilege not kernel"); // R11

  AST_NORMAL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && cls_q == CLS_NORMAL) |-> (ent_pc[4:0] == 5'd0)) else $error("normal vector misaligned"); // R5

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && cls_q == CLS_RESET) |-> (ent_pc == RESET_VEC && out_erl)) else $error("reset entry wrong"); // R8

  AST_DEBUG_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && cls_q == CLS_DEBUG) |-> (ent_pc == DEBUG_VEC && out_dbg_mode)) else $error("debug entry wrong"); // R9

  AST_DEBUG_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && cls_q == CLS_DEBUG) |-> ($countones(out_dbg_flags & ~$past(dbg_flags_in)) <= 1)) else $error("several debug flags"); // R9

endmodule

bind exc_entry_ctrl exc_entry_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exc_valid     (exc_valid),
  .st_exl        (st_exl),
  .epc_in        (epc_in),
  .dbg_flags_in  (dbg_flags_in),
  .ent_valid     (ent_valid),
  .ent_pc        (ent_pc),
  .out_erl       (out_erl),
  .out_dbg_mode  (out_dbg_mode),
  .out_ksu       (out_ksu),
  .out_epc       (out_epc),
  .out_dbg_flags (out_dbg_flags),
  .cls_now       (cls_now),
  .cls_q         (cls_q)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int IP_W       = 8;
  localparam int SPACE_W    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 1'b0;
  logic [4:0] exc_kind = '0;
  logic exc_refill = 1'b0;
  logic [1:0] exc_cop = '0;
  logic [31:0] cur_pc = '0;
  logic in_dslot = 1'b0, dslot_b16 = 1'b0, isa16 = 1'b0;
  logic st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0, st_sr = 1'b0, st_nmi = 1'b0;
  logic [1:0] st_ksu = '0;
  logic ca_iv = 1'b0, ca_bd = 1'b0;
  logic [4:0] ca_code = '0;
  logic [1:0] ca_ce = '0;
  logic [IP_W-1:0] ca_ip = '0;
  logic [31:0] ebase = '0;
  logic vi_internal = 1'b0, vi_external = 1'b0;
  logic [SPACE_W-1:0] vi_space = '0;
  logic [31:0] epc_in = '0, errepc_in = '0, depc_in = '0;
  logic dbg_mode_in = 1'b0;
  logic [5:0] dbg_flags_in = '0;

  logic ent_valid;
  logic [31:0] ent_pc;
  logic out_exl, out_erl, out_bev, out_sr, out_nmi, out_bd, out_dbg_mode;
  logic [1:0] out_ksu, out_ce;
  logic [4:0] out_code;
  logic [31:0] out_epc, out_errepc, out_depc;
  logic [5:0] out_dbg_flags;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .exc_refill(exc_refill), .exc_cop(exc_cop), .cur_pc(cur_pc),
    .in_dslot(in_dslot), .dslot_b16(dslot_b16), .isa16(isa16),
    .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev), .st_sr(st_sr),
    .st_nmi(st_nmi), .st_ksu(st_ksu), .ca_iv(ca_iv), .ca_bd(ca_bd),
    .ca_code(ca_code), .ca_ce(ca_ce), .ca_ip(ca_ip), .ebase(ebase),
    .vi_internal(vi_internal), .vi_external(vi_external), .vi_space(vi_space),
    .epc_in(epc_in), .errepc_in(errepc_in), .depc_in(depc_in),
    .dbg_mode_in(dbg_mode_in), .dbg_flags_in(dbg_flags_in),
    .ent_valid(ent_valid), .ent_pc(ent_pc), .out_exl(out_exl),
    .out_erl(out_erl), .out_bev(out_bev), .out_sr(out_sr), .out_nmi(out_nmi),
    .out_ksu(out_ksu), .out_bd(out_bd), .out_code(out_code), .out_ce(out_ce),
    .out_epc(out_epc), .out_errepc(out_errepc), .out_depc(out_depc),
    .out_dbg_mode(out_dbg_mode), .out_dbg_flags(out_dbg_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // expected image
  logic        e_valid, e_exl, e_erl, e_bev, e_sr, e_nmi, e_bd, e_dbgm;
  logic [1:0]  e_ksu, e_ce;
  logic [4:0]  e_code;
  logic [31:0] e_pc, e_epc, e_errepc, e_depc;
  logic [5:0]  e_flags;
  string       t_pc, t_st;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // expected result computed from the requirement text
  task automatic predict();
    int kk;
    logic [31:0] rp, base, off, vec;
    kk = int'(exc_kind);
    rp = (cur_pc | {31'd0, isa16}) - (in_dslot ? (dslot_b16 ? 32'd2 : 32'd4) : 32'd0); // R3
    e_valid = 1'b1; e_exl = st_exl; e_erl = st_erl; e_bev = st_bev; e_sr = st_sr;
    e_nmi = st_nmi; e_bd = ca_bd; e_dbgm = dbg_mode_in; e_ksu = 2'b00; e_ce = ca_ce;
    e_code = ca_code; e_epc = epc_in; e_errepc = errepc_in; e_depc = depc_in;
    e_flags = dbg_flags_in; e_pc = 32'h0;
    if (kk <= 2) begin // R8
      t_pc = "R8"; t_st = "R8";
      e_errepc = rp; e_erl = 1'b1; e_bev = 1'b1;
      if (kk == 1) e_sr = 1'b1;
      if (kk == 2) e_nmi = 1'b1;
      if (!st_exl) e_bd = 1'b0;
      e_pc = 32'hBFC0_0000;
    end else if (kk <= 8 || (kk == 9 && dbg_mode_in)) begin // R9 R10
      t_pc = (kk == 9) ? "R10" : "R9"; t_st = t_pc;
      case (kk)
        3: e_flags[0] = 1'b1;
        6: e_flags[1] = 1'b1;
        8: e_flags[2] = 1'b1;
        7: e_flags[3] = 1'b1;
        5: e_flags[4] = 1'b1;
        default: e_flags[5] = 1'b1;
      endcase
      e_depc = (kk == 3) ? (cur_pc | {31'd0, isa16}) : rp;
      e_dbgm = 1'b1;
      if (!st_exl) e_bd = 1'b0;
      e_pc = 32'hBFC0_0480;
    end else if (kk <= 20) begin // R4 R5 R6 R7
      t_pc = (kk == 9) ? "R6" : "R5"; t_st = "R4";
      if (!st_exl) begin e_epc = rp; e_bd = in_dslot; end
      e_exl = 1'b1;
      e_code = (kk <= 14) ? 5'(kk - 9) : 5'(kk - 7);
      if (kk == 18) e_ce = exc_cop;
      base = st_bev ? 32'hBFC0_0200 : {ebase[31:10], 10'd0};
      if (kk == 9) begin
        if (!ca_iv) off = 32'h180;
        else if (vi_internal || vi_external) begin
          vec = 32'd0;
          if (vi_internal) begin
            for (int b = 0; b < IP_W; b++) if (ca_ip[b]) vec = b;
          end else vec = {24'd0, ca_ip};
          off = 32'h200 + vec * ({27'd0, vi_space} * 32'd32);
        end else off = 32'h200;
      end else if ((kk == 11 || kk == 12) && exc_refill && !st_exl) off = 32'h0;
      else off = 32'h180;
      e_pc = base + off;
    end else begin
      e_valid = 1'b0;
    end
  endtask

  task automatic apply_and_check();
    logic [31:0] prev_pc, prev_epc, prev_depc;
    prev_pc = ent_pc; prev_epc = out_epc; prev_depc = out_depc;
    predict();
    exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
    if (!e_valid) begin
      chk("R2", "no valid for unused kind", {31'd0, ent_valid}, 32'd0);
      chk("R2", "pc held", ent_pc, prev_pc);
      chk("R2", "epc held", out_epc, prev_epc);
      chk("R2", "depc held", out_depc, prev_depc);
    end else begin
      chk("R2", "valid", {31'd0, ent_valid}, 32'd1);
      chk(t_pc, "handler pc", ent_pc, e_pc);
      chk(t_st, "exl", {31'd0, out_exl}, {31'd0, e_exl});
      chk(t_st, "erl", {31'd0, out_erl}, {31'd0, e_erl});
      chk(t_st, "bev", {31'd0, out_bev}, {31'd0, e_bev});
      chk(t_st, "sr", {31'd0, out_sr}, {31'd0, e_sr});
      chk(t_st, "nmi", {31'd0, out_nmi}, {31'd0, e_nmi});
      chk(t_st, "bd", {31'd0, out_bd}, {31'd0, e_bd});
      chk("R11", "ksu", {30'd0, out_ksu}, {30'd0, e_ksu});
      chk("R7", "code", {27'd0, out_code}, {27'd0, e_code});
      chk("R7", "ce", {30'd0, out_ce}, {30'd0, e_ce});
      chk("R3", "epc", out_epc, e_epc);
      chk("R3", "errepc", out_errepc, e_errepc);
      chk("R3", "depc", out_depc, e_depc);
      chk(t_st, "debug mode", {31'd0, out_dbg_mode}, {31'd0, e_dbgm});
      chk(t_st, "debug flags", {26'd0, out_dbg_flags}, {26'd0, e_flags});
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {31'd0, ent_valid}, 32'd0);
    chk("R1", "pc in reset", ent_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", {31'd0, ent_valid}, 32'd0);
    chk("R1", "epc after reset", out_epc, 32'd0);
    chk("R1", "flags after reset", {26'd0, out_dbg_flags}, 32'd0);
    chk("R1", "exl after reset", {31'd0, out_exl}, 32'd0);

    // sweep over every kind and class-relevant flag
    ca_iv = 1'b0; ca_ip = 8'h44; ca_bd = 1'b1; ca_code = 5'h1F; ca_ce = 2'b10;
    st_ksu = 2'b10; st_sr = 1'b0; st_nmi = 1'b0;
    for (int k = 0; k < 32; k++)
      for (int x = 0; x < 2; x++)
        for (int dm = 0; dm < 2; dm++)
          for (int ds = 0; ds < 3; ds++)
            for (int bv = 0; bv < 2; bv++)
              for (int is = 0; is < 2; is++) begin
                exc_kind = 5'(k);
                st_exl = x[0]; st_erl = ~x[0]; dbg_mode_in = dm[0];
                in_dslot = (ds != 0); dslot_b16 = (ds == 2);
                st_bev = bv[0]; isa16 = is[0]; exc_refill = bv[0] ^ is[0];
                exc_cop = 2'(k);
                cur_pc = 32'h8040_0000 | (32'(k) << 6) | (32'(ds) << 3);
                ebase = 32'h8123_4FFF ^ (32'(k) << 12);
                epc_in = 32'hE0E0_0000 | 32'(k);
                errepc_in = 32'h5555_0000 | 32'(k);
                depc_in = 32'h6666_0000 | 32'(k);
                dbg_flags_in = 6'(k) & 6'h15;
                apply_and_check();
              end

    // interrupt offset sweep (R6)
    exc_kind = 5'd9; dbg_mode_in = 1'b0; st_exl = 1'b0; st_bev = 1'b0;
    in_dslot = 1'b0; isa16 = 1'b0; ebase = 32'h9000_0000; cur_pc = 32'h8000_2000;
    for (int iv = 0; iv < 2; iv++)
      for (int m = 0; m < 4; m++)
        for (int sp = 0; sp < 32; sp++)
          for (int p = 0; p < 8; p++) begin
            ca_iv = iv[0]; vi_internal = m[0]; vi_external = m[1];
            vi_space = 5'(sp);
            case (p)
              0: ca_ip = 8'h00; 1: ca_ip = 8'h01; 2: ca_ip = 8'h80; 3: ca_ip = 8'h5A;
              4: ca_ip = 8'h03; 5: ca_ip = 8'h24; 6: ca_ip = 8'hFF; default: ca_ip = 8'h10;
            endcase
            apply_and_check();
          end

    // an idle cycle gives no entry (R2)
    @(negedge clk);
    chk("R2", "idle cycle no valid", {31'd0, ent_valid}, 32'd0);
    finish_run();
  end

endmodule